// File: doc/BRIEF.md
# Fine-Grained Thread Select Unit

This block chooses, every clock cycle, which of a small group of hardware threads gets the single issue slot of a shared in-order pipeline. Eligible threads take turns in a fixed round-robin order, one instruction from one thread per cycle. The search for the next thread always begins at the thread after the one last chosen.

Each thread can be parked for four separate reasons: a fetched instruction whose predecode bit marks it as long-latency, a miss in a blocking cache, entry into a trap handler, and a resource conflict. Each reason has its own start strobe and end strobe, and each strobe carries a thread number. A thread is eligible only when none of its four reasons is pending. The arbiter passes over parked threads. When no thread is eligible, the valid output drops and the round-robin pointer holds its position.

Top module: `thread_issue_select`

## Requirements
- R1: After reset every thread is eligible, the valid output is high and thread 0 is selected in the first cycle.
- R2: With all threads eligible, the selected thread advances by one each cycle and wraps from NUM_THREADS-1 to 0.
- R3: A long-latency predecode strobe for thread t excludes t from the following cycle on. A long-latency completion strobe for t removes that reason.
- R4: A cache miss strobe for thread t excludes t from the following cycle on. A miss return strobe for t removes that reason.
- R5: A trap entry strobe for thread t excludes t from the following cycle on. A trap exit strobe for t removes that reason.
- R6: A resource conflict strobe for thread t excludes t from the following cycle on. A conflict clear strobe for t removes that reason.
- R7: The selected thread is the first eligible thread found by searching upward, with wrap-around, from the thread after the last valid selection.
- R8: When no thread is eligible, sel_valid_o is low, sel_tid_o is 0, and the pointer is not moved.
- R9: When the start and end strobes of the same reason name the same thread in the same cycle, the end strobe wins and that reason is clear afterwards.
- R10: A thread with several pending reasons stays excluded until every one of them has ended.
- R11: A strobe for one thread changes the eligibility of no other thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ll_fetch_i | input | 1 | Fetched instruction predecoded as long-latency |
| ll_fetch_tid_i | input | TID_W | Thread of ll_fetch_i |
| ll_done_i | input | 1 | Long-latency operation completed |
| ll_done_tid_i | input | TID_W | Thread of ll_done_i |
| miss_i | input | 1 | Blocking cache miss |
| miss_tid_i | input | TID_W | Thread of miss_i |
| fill_i | input | 1 | Miss data returned |
| fill_tid_i | input | TID_W | Thread of fill_i |
| trap_enter_i | input | 1 | Trap taken |
| trap_enter_tid_i | input | TID_W | Thread of trap_enter_i |
| trap_exit_i | input | 1 | Trap handling finished |
| trap_exit_tid_i | input | TID_W | Thread of trap_exit_i |
| rsrc_busy_i | input | 1 | Resource conflict detected |
| rsrc_busy_tid_i | input | TID_W | Thread of rsrc_busy_i |
| rsrc_free_i | input | 1 | Resource conflict cleared |
| rsrc_free_tid_i | input | TID_W | Thread of rsrc_free_i |
| sel_valid_o | output | 1 | A thread is selected this cycle |
| sel_tid_o | output | TID_W | Selected thread, 0 when invalid |

## Verification
The properties assume that every thread number presented on a strobe lies below NUM_THREADS. They also assume a start strobe is not expected to stick when its matching end strobe names the same thread in that same cycle. The exclusion properties therefore hold back their claim in exactly that case. The bench uses the default group of four threads, so every 2-bit thread code is a real thread. Start and end strobes of one reason coincide only in the directed case that targets that precedence.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
  localparam int NUM_CAUSE = 4;

  typedef enum logic [1:0] {
    CAUSE_LL   = 2'd0,
    CAUSE_MISS = 2'd1,
    CAUSE_TRAP = 2'd2,
    CAUSE_RSRC = 2'd3
  } cause_e;
endpackage

// File: rtl/tsel_cause_reg.sv
// One park reason, one flag per thread; end strobe beats start strobe.
module tsel_cause_reg #(
  parameter int NUM_THREADS = 4,
  localparam int TID_W = $clog2(NUM_THREADS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   set_i,
  input  logic [TID_W-1:0]       set_tid_i,
  input  logic                   clr_i,
  input  logic [TID_W-1:0]       clr_tid_i,
  output logic [NUM_THREADS-1:0] held_o
);
  logic [NUM_THREADS-1:0] held_q;

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    logic hit_set, hit_clr;
    assign hit_set = set_i && (set_tid_i == TID_W'(t));
    assign hit_clr = clr_i && (clr_tid_i == TID_W'(t));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      held_q[t] <= 1'b0;
      else if (hit_clr) held_q[t] <= 1'b0;
      else if (hit_set) held_q[t] <= 1'b1;
    end
  end

  assign held_o = held_q;
endmodule

// File: rtl/tsel_block_track.sv
module tsel_block_track
  import tsel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  localparam int TID_W = $clog2(NUM_THREADS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_CAUSE-1:0]   set_i,
  input  logic [TID_W-1:0]       set_tid_i [NUM_CAUSE],
  input  logic [NUM_CAUSE-1:0]   clr_i,
  input  logic [TID_W-1:0]       clr_tid_i [NUM_CAUSE],
  output logic [NUM_THREADS-1:0] active_o
);
  logic [NUM_THREADS-1:0] held [NUM_CAUSE];

  for (genvar c = 0; c < NUM_CAUSE; c++) begin : g_cause
    tsel_cause_reg #(.NUM_THREADS(NUM_THREADS)) u_reg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (set_i[c]),
      .set_tid_i (set_tid_i[c]),
      .clr_i     (clr_i[c]),
      .clr_tid_i (clr_tid_i[c]),
      .held_o    (held[c])
    );
  end

  always_comb begin
    logic [NUM_THREADS-1:0] any_held;
    any_held = '0;
    for (int c = 0; c < NUM_CAUSE; c++) any_held |= held[c];
    active_o = ~any_held;
  end
endmodule

// File: rtl/tsel_rr_pick.sv
// Round-robin search from the thread after the last valid pick.
module tsel_rr_pick #(
  parameter int NUM_THREADS = 4,
  localparam int TID_W = $clog2(NUM_THREADS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_THREADS-1:0] active_i,
  output logic                   pick_valid_o,
  output logic [TID_W-1:0]       pick_tid_o
);
  logic [TID_W-1:0] last_q;

  always_comb begin
    pick_valid_o = 1'b0;
    pick_tid_o   = '0;
    for (int off = 1; off <= NUM_THREADS; off++) begin
      int idx;
      idx = (int'(last_q) + off) % NUM_THREADS;
      if (!pick_valid_o && active_i[idx]) begin
        pick_valid_o = 1'b1;
        pick_tid_o   = TID_W'(idx);
      end
    end
  end

  // Reset to the top thread so thread 0 wins first.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           last_q <= TID_W'(NUM_THREADS - 1);
    else if (pick_valid_o) last_q <= pick_tid_o;
  end
endmodule

// File: rtl/thread_issue_select.sv
module thread_issue_select
  import tsel_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  localparam int TID_W = $clog2(NUM_THREADS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ll_fetch_i,
  input  logic [TID_W-1:0] ll_fetch_tid_i,
  input  logic             ll_done_i,
  input  logic [TID_W-1:0] ll_done_tid_i,
  input  logic             miss_i,
  input  logic [TID_W-1:0] miss_tid_i,
  input  logic             fill_i,
  input  logic [TID_W-1:0] fill_tid_i,
  input  logic             trap_enter_i,
  input  logic [TID_W-1:0] trap_enter_tid_i,
  input  logic             trap_exit_i,
  input  logic [TID_W-1:0] trap_exit_tid_i,
  input  logic             rsrc_busy_i,
  input  logic [TID_W-1:0] rsrc_busy_tid_i,
  input  logic             rsrc_free_i,
  input  logic [TID_W-1:0] rsrc_free_tid_i,
  output logic             sel_valid_o,
  output logic [TID_W-1:0] sel_tid_o
);
  logic [NUM_CAUSE-1:0]   set_vec, clr_vec;
  logic [TID_W-1:0]       set_tid [NUM_CAUSE];
  logic [TID_W-1:0]       clr_tid [NUM_CAUSE];
  logic [NUM_THREADS-1:0] active_mask;

  always_comb begin
    set_vec[CAUSE_LL]   = ll_fetch_i;    set_tid[CAUSE_LL]   = ll_fetch_tid_i;
    clr_vec[CAUSE_LL]   = ll_done_i;     clr_tid[CAUSE_LL]   = ll_done_tid_i;
    set_vec[CAUSE_MISS] = miss_i;        set_tid[CAUSE_MISS] = miss_tid_i;
    clr_vec[CAUSE_MISS] = fill_i;        clr_tid[CAUSE_MISS] = fill_tid_i;
    set_vec[CAUSE_TRAP] = trap_enter_i;  set_tid[CAUSE_TRAP] = trap_enter_tid_i;
    clr_vec[CAUSE_TRAP] = trap_exit_i;   clr_tid[CAUSE_TRAP] = trap_exit_tid_i;
    set_vec[CAUSE_RSRC] = rsrc_busy_i;   set_tid[CAUSE_RSRC] = rsrc_busy_tid_i;
    clr_vec[CAUSE_RSRC] = rsrc_free_i;   clr_tid[CAUSE_RSRC] = rsrc_free_tid_i;
  end

  tsel_block_track #(.NUM_THREADS(NUM_THREADS)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_vec),
    .set_tid_i (set_tid),
    .clr_i     (clr_vec),
    .clr_tid_i (clr_tid),
    .active_o  (active_mask)
  );

  tsel_rr_pick #(.NUM_THREADS(NUM_THREADS)) u_pick (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .active_i     (active_mask),
    .pick_valid_o (sel_valid_o),
    .pick_tid_o   (sel_tid_o)
  );
endmodule

// File: rtl/tsel_sva.sv
module tsel_sva #(
  parameter int NUM_THREADS = 4,
  localparam int TID_W = $clog2(NUM_THREADS)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   ll_fetch_i,
  input logic [TID_W-1:0]       ll_fetch_tid_i,
  input logic                   ll_done_i,
  input logic [TID_W-1:0]       ll_done_tid_i,
  input logic                   miss_i,
  input logic [TID_W-1:0]       miss_tid_i,
  input logic                   fill_i,
  input logic [TID_W-1:0]       fill_tid_i,
  input logic                   trap_enter_i,
  input logic [TID_W-1:0]       trap_enter_tid_i,
  input logic                   trap_exit_i,
  input logic [TID_W-1:0]       trap_exit_tid_i,
  input logic                   rsrc_busy_i,
  input logic [TID_W-1:0]       rsrc_busy_tid_i,
  input logic                   rsrc_free_i,
  input logic [TID_W-1:0]       rsrc_free_tid_i,
  input logic                   sel_valid_o,
  input logic [TID_W-1:0]       sel_tid_o,
  input logic [NUM_THREADS-1:0] active_mask
);
  logic [TID_W-1:0] succ_tid;
  assign succ_tid = (sel_tid_o == TID_W'(NUM_THREADS - 1)) ? '0 : sel_tid_o + 1'b1;

  assert_rr_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_valid_o && (&active_mask)) |=>
      (!(&active_mask) || sel_tid_o == $past(succ_tid)));

  assert_ll_parks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ll_fetch_i && !(ll_done_i && ll_done_tid_i == ll_fetch_tid_i)) |=>
      !(sel_valid_o && sel_tid_o == $past(ll_fetch_tid_i)));

  assert_miss_parks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_i && !(fill_i && fill_tid_i == miss_tid_i)) |=>
      !(sel_valid_o && sel_tid_o == $past(miss_tid_i)));

  assert_trap_parks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_enter_i && !(trap_exit_i && trap_exit_tid_i == trap_enter_tid_i)) |=>
      !(sel_valid_o && sel_tid_o == $past(trap_enter_tid_i)));

  assert_rsrc_parks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsrc_busy_i && !(rsrc_free_i && rsrc_free_tid_i == rsrc_busy_tid_i)) |=>
      !(sel_valid_o && sel_tid_o == $past(rsrc_busy_tid_i)));

  assert_pick_eligible_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o |-> active_mask[sel_tid_o]);

  assert_idle_when_none_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_mask == '0) |-> (!sel_valid_o && sel_tid_o == '0));

  assert_valid_when_any_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_mask != '0) |-> sel_valid_o);
endmodule

bind thread_issue_select tsel_sva #(.NUM_THREADS(NUM_THREADS)) u_sva (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .ll_fetch_i       (ll_fetch_i),
  .ll_fetch_tid_i   (ll_fetch_tid_i),
  .ll_done_i        (ll_done_i),
  .ll_done_tid_i    (ll_done_tid_i),
  .miss_i           (miss_i),
  .miss_tid_i       (miss_tid_i),
  .fill_i           (fill_i),
  .fill_tid_i       (fill_tid_i),
  .trap_enter_i     (trap_enter_i),
  .trap_enter_tid_i (trap_enter_tid_i),
  .trap_exit_i      (trap_exit_i),
  .trap_exit_tid_i  (trap_exit_tid_i),
  .rsrc_busy_i      (rsrc_busy_i),
  .rsrc_busy_tid_i  (rsrc_busy_tid_i),
  .rsrc_free_i      (rsrc_free_i),
  .rsrc_free_tid_i  (rsrc_free_tid_i),
  .sel_valid_o      (sel_valid_o),
  .sel_tid_o        (sel_tid_o),
  .active_mask      (active_mask)
);

// File: tb/thread_issue_select_tb_top.sv
module thread_issue_select_tb_top;
  localparam int NT = 4;
  localparam int TW = 2;
  localparam int NSTEP = 13;

  // step = {op[3:0], tid[1:0], exp_valid, exp_tid[1:0]}
  // op: 0 none, 1 ll start, 2 ll end, 3 miss, 4 fill, 5 trap in, 6 trap out, 7 conflict, 8 conflict clear
  localparam logic [8:0] STEPS [NSTEP] = '{
    {4'd0, 2'd0, 1'b1, 2'd1},
    {4'd0, 2'd0, 1'b1, 2'd2},
    {4'd1, 2'd3, 1'b1, 2'd0},
    {4'd3, 2'd1, 1'b1, 2'd2},
    {4'd5, 2'd2, 1'b1, 2'd0},
    {4'd7, 2'd0, 1'b0, 2'd0},
    {4'd4, 2'd1, 1'b1, 2'd1},
    {4'd0, 2'd0, 1'b1, 2'd1},
    {4'd2, 2'd3, 1'b1, 2'd3},
    {4'd6, 2'd2, 1'b1, 2'd1},
    {4'd8, 2'd0, 1'b1, 2'd2},
    {4'd0, 2'd0, 1'b1, 2'd3},
    {4'd0, 2'd0, 1'b1, 2'd0}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic ll_f, ll_d, ms, fl, tin, tout, rb, rf;
  logic [TW-1:0] ll_f_t, ll_d_t, ms_t, fl_t, tin_t, tout_t, rb_t, rf_t;
  logic sel_v;
  logic [TW-1:0] sel_t;
  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  thread_issue_select #(.NUM_THREADS(NT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ll_fetch_i(ll_f), .ll_fetch_tid_i(ll_f_t),
    .ll_done_i(ll_d), .ll_done_tid_i(ll_d_t),
    .miss_i(ms), .miss_tid_i(ms_t),
    .fill_i(fl), .fill_tid_i(fl_t),
    .trap_enter_i(tin), .trap_enter_tid_i(tin_t),
    .trap_exit_i(tout), .trap_exit_tid_i(tout_t),
    .rsrc_busy_i(rb), .rsrc_busy_tid_i(rb_t),
    .rsrc_free_i(rf), .rsrc_free_tid_i(rf_t),
    .sel_valid_o(sel_v), .sel_tid_o(sel_t)
  );

  task automatic idle();
    {ll_f, ll_d, ms, fl, tin, tout, rb, rf} = '0;
    {ll_f_t, ll_d_t, ms_t, fl_t, tin_t, tout_t, rb_t, rf_t} = '0;
  endtask

  task automatic drive_op(input logic [3:0] op, input logic [TW-1:0] t);
    idle();
    case (op)
      4'd1: begin ll_f = 1'b1; ll_f_t = t; end
      4'd2: begin ll_d = 1'b1; ll_d_t = t; end
      4'd3: begin ms   = 1'b1; ms_t   = t; end
      4'd4: begin fl   = 1'b1; fl_t   = t; end
      4'd5: begin tin  = 1'b1; tin_t  = t; end
      4'd6: begin tout = 1'b1; tout_t = t; end
      4'd7: begin rb   = 1'b1; rb_t   = t; end
      4'd8: begin rf   = 1'b1; rf_t   = t; end
      default: ;
    endcase
  endtask

  task automatic check(input string req, input logic ev, input logic [TW-1:0] et);
    n_cmp++;
    if (sel_v !== ev || sel_t !== et) begin
      n_bad++;
      $display("FAIL %s: valid=%0b tid=%0d expected valid=%0b tid=%0d",
               req, sel_v, sel_t, ev, et);
    end
  endtask

  function automatic string tag_of(input logic [3:0] op, input logic ev);
    string s;
    case (op)
      4'd1, 4'd2: s = "R3 R7 R11";
      4'd3, 4'd4: s = "R4 R7 R11";
      4'd5, 4'd6: s = "R5 R7 R11";
      4'd7, 4'd8: s = "R6 R7 R11";
      default:    s = "R2 R7";
    endcase
    if (!ev) s = {s, " R8"};
    return s;
  endfunction

  task automatic do_reset();
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 reset selects thread 0", 1'b1, 2'd0);

    for (int i = 0; i < NSTEP; i++) begin
      drive_op(STEPS[i][8:5], STEPS[i][4:3]);
      @(negedge clk);
      idle();
      check(tag_of(STEPS[i][8:5], STEPS[i][2]), STEPS[i][2], STEPS[i][1:0]);
    end

    // Directed corner cases from a fresh reset
    do_reset();
    check("R1 second reset", 1'b1, 2'd0);

    // R9: miss and fill on thread 2 together; other threads parked by other reasons
    idle();
    ll_f = 1'b1; ll_f_t = 2'd0;
    tin  = 1'b1; tin_t  = 2'd1;
    rb   = 1'b1; rb_t   = 2'd3;
    ms   = 1'b1; ms_t   = 2'd2;
    fl   = 1'b1; fl_t   = 2'd2;
    @(negedge clk);
    idle();
    check("R9 end strobe wins", 1'b1, 2'd2);

    // R10: park thread 2 for two reasons
    ms = 1'b1; ms_t = 2'd2;
    tin = 1'b1; tin_t = 2'd2;
    @(negedge clk);
    idle();
    check("R8 all parked", 1'b0, 2'd0);

    fl = 1'b1; fl_t = 2'd2;
    @(negedge clk);
    idle();
    check("R10 trap still pending", 1'b0, 2'd0);

    tout = 1'b1; tout_t = 2'd2;
    @(negedge clk);
    idle();
    check("R10 all reasons ended", 1'b1, 2'd2);

    // R8: pointer held while idle, so thread 2 alone keeps winning
    @(negedge clk);
    check("R8 R7 sole thread repeats", 1'b1, 2'd2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule